// File: doc/BRIEF.md
# Variable-Size Byte Pointer Unpacker

This block steps through a buffer of 36-bit host words and hands out one byte per request to a 16-bit consumer. A descriptor sets three things: a byte-size code, a word count and an 18-bit word address. Bytes are taken from each fetched word starting at its most significant end. Low-order bits left over after the last whole byte are skipped. Each delivered byte is zero-extended to 16 bits.

The block fetches a word through a simple read port and then serves bytes from a local copy of it. When the last byte of that word goes out, the address moves up by one and the word count moves down by one. A request that arrives once the count has reached zero does not return data. Instead it raises a one-cycle word-count overflow pulse. The current address, count and byte position are always visible at the ports.

The controller is a four-state machine:

- `S_IDLE` means no descriptor has been taken yet.
- `S_READY` means a descriptor is held but no word is buffered.
- `S_FETCH` means a read is outstanding.
- `S_HOLD` means a word is buffered and its remaining bytes can be served.

Its transitions are:

- The load transition (`S_IDLE`/`S_READY`/`S_HOLD` to `S_READY` on an accepted load).
- The fetch transition (`S_READY` to `S_FETCH` on a request with a non-zero count).
- The fill transition (`S_FETCH` to `S_HOLD` on read data).
- The word-done transition (`S_HOLD` to `S_READY` when the last byte of the word is taken).

Top module: `bpu_unpacker`

## Requirements
- R1: After reset `rdy`, `byte_valid`, `mem_rd_en`, `wc_ovf` and `size_err` are 0, and `cur_pos` is 0.
- R2: The size code is mapped as follows. Code 2 gives a byte width of 16 and 2 bytes per word. Code 3 gives 12 and 3. Code 4 gives 8 and 4. Code 5 gives 7 and 5. Code 6 gives 6 and 6.
- R3: Byte k (counting from 0) of a word of width w is taken from `mem_rd_data[35-k*w -: w]`. Bit 35 is the first bit of the word. The byte appears on `byte_data` zero-extended to 16 bits.
- R4: One read is made per word. `mem_rd_en` is a one-cycle pulse with `mem_rd_addr` equal to `cur_addr`. It is issued only for a request in `S_READY` with a non-zero count.
- R5: The last byte of a word is delivered in some cycle. From that same cycle, `cur_addr` has increased by 1 (wrapping at 18 bits), `cur_count` has decreased by 1, and `cur_pos` is 0.
- R6: A request in `S_READY` with `cur_count` = 0 gives `wc_ovf` = 1 for one cycle in the next cycle. It causes no read and no byte. Address, count and position are unchanged.
- R7: A load with size code 0, 1 or 7 gives `size_err` = 1 in the next cycle. It causes no read. The state, address, count and position are left unchanged.
- R8: A load presented while a read is outstanding (`S_FETCH`) is ignored.
- R9: `byte_req` has no effect while `rdy` = 0. `rdy` is 1 exactly in `S_READY` and `S_HOLD`.
- R10: An accepted load sets `cur_addr` and `cur_count` from the descriptor, sets `cur_pos` to 0 and makes `rdy` = 1 in the next cycle. It also discards any partly used buffered word. A request in the same cycle as a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Take a new descriptor |
| ld_size | input | 3 | Descriptor size code |
| ld_count | input | CNT_W | Descriptor word count |
| ld_addr | input | ADDR_W | Descriptor start word address |
| byte_req | input | 1 | Request the next byte |
| rdy | output | 1 | Block can accept a request |
| byte_valid | output | 1 | `byte_data` holds a delivered byte this cycle |
| byte_data | output | 16 | Delivered byte, zero-extended |
| mem_rd_en | output | 1 | Word read strobe |
| mem_rd_addr | output | ADDR_W | Word read address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 36 | Returned word |
| wc_ovf | output | 1 | Word-count overflow pulse |
| size_err | output | 1 | Rejected size code pulse |
| cur_addr | output | ADDR_W | Current word address |
| cur_count | output | CNT_W | Remaining word count |
| cur_pos | output | 3 | Index of the next byte in the buffered word |

## Verification
Faults in the held state show up at the ports in different ways:

- A wrong byte position shows up as a byte with the wrong value on the very next delivery, because the scoreboard holds every expected byte in order.
- A wrong address shows up as wrong data on the first byte of the next word, since the read address selects the returned pattern. It also shows up directly on `cur_addr` at the end of the word.
- A count that is off by one shows up as an early or a missing `wc_ovf` once the buffer is used up.
- A state machine that misses the word-done transition gives the wrong number of reads, which shows up as a stale byte after the last one of a word.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    localparam int WORD_W  = 36;
    localparam int OUT_W   = 16;
    localparam int MAX_BPW = 6;
    localparam int POS_W   = $clog2(MAX_BPW + 1);
    localparam int WID_W   = $clog2(OUT_W + 1);

    typedef enum logic [1:0] {
        S_IDLE,
        S_READY,
        S_FETCH,
        S_HOLD
    } bpu_state_e;

    function automatic logic code_ok(input logic [2:0] code);
        return (code >= 3'd2) && (code <= 3'd6);
    endfunction
endpackage

// File: rtl/bpu_size_decode.sv
module bpu_size_decode
    import bpu_pkg::*;
(
    input  logic [2:0]       code,
    output logic [WID_W-1:0] width,
    output logic [POS_W-1:0] per_word,
    output logic             ok
);
    always_comb begin
        unique case (code)
            3'd2:    begin width = WID_W'(16); per_word = POS_W'(2); ok = 1'b1; end
            3'd3:    begin width = WID_W'(12); per_word = POS_W'(3); ok = 1'b1; end
            3'd4:    begin width = WID_W'(8);  per_word = POS_W'(4); ok = 1'b1; end
            3'd5:    begin width = WID_W'(7);  per_word = POS_W'(5); ok = 1'b1; end
            3'd6:    begin width = WID_W'(6);  per_word = POS_W'(6); ok = 1'b1; end
            default: begin width = '0;         per_word = '0;        ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/bpu_byte_extract.sv
module bpu_byte_extract
    import bpu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [WID_W-1:0]  width,
    input  logic [POS_W-1:0]  pos,
    output logic [OUT_W-1:0]  byte_out
);
    localparam int SH_W = $clog2(WORD_W + 1);

    logic [SH_W-1:0]   end_bit;
    logic [SH_W-1:0]   shift;
    logic [WORD_W-1:0] shifted;
    logic [OUT_W:0]    mask_w;

    always_comb begin
        // bits consumed from the top once this byte is taken
        end_bit  = SH_W'((SH_W'(pos) + SH_W'(1)) * SH_W'(width));
        shift    = SH_W'(WORD_W) - end_bit;
        shifted  = word >> shift;
        mask_w   = (( (OUT_W+1)'(1)) << width) - (OUT_W+1)'(1);
        byte_out = OUT_W'(shifted & WORD_W'(mask_w));
    end
endmodule

// File: rtl/bpu_unpacker.sv
module bpu_unpacker
    import bpu_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [2:0]        ld_size,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              byte_req,
    output logic              rdy,
    output logic              byte_valid,
    output logic [OUT_W-1:0]  byte_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              wc_ovf,
    output logic              size_err,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic [POS_W-1:0]  cur_pos
);
    bpu_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [POS_W-1:0]  pos_q;
    logic [2:0]        code_q;
    logic [WORD_W-1:0] word_q;

    logic [WID_W-1:0]  cur_width;
    logic [POS_W-1:0]  cur_bpw;
    logic              cur_ok;
    logic [WORD_W-1:0] src_word;
    logic [OUT_W-1:0]  ext_byte;

    logic ld_open, ld_take, ld_bad, req_live, last_byte, cnt_zero;

    bpu_size_decode u_dec (
        .code     (code_q),
        .width    (cur_width),
        .per_word (cur_bpw),
        .ok       (cur_ok)
    );

    assign src_word = (state == S_FETCH) ? mem_rd_data : word_q;

    bpu_byte_extract u_ext (
        .word     (src_word),
        .width    (cur_width),
        .pos      (pos_q),
        .byte_out (ext_byte)
    );

    assign ld_open   = load && (state != S_FETCH);
    assign ld_take   = ld_open && code_ok(ld_size);
    assign ld_bad    = ld_open && !code_ok(ld_size);
    assign req_live  = byte_req && !load;
    assign cnt_zero  = (cnt_q == '0);
    assign last_byte = cur_ok && (pos_q == cur_bpw - POS_W'(1));

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (ld_take) state_nx = S_READY;
            S_READY: begin
                if (ld_take)                   state_nx = S_READY;
                else if (req_live && !cnt_zero) state_nx = S_FETCH;
            end
            S_FETCH: if (mem_rd_valid) state_nx = S_HOLD;
            S_HOLD: begin
                if (ld_take)                     state_nx = S_READY;
                else if (req_live && last_byte)  state_nx = S_READY;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // pointer, buffer and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            cnt_q      <= '0;
            pos_q      <= '0;
            code_q     <= '0;
            word_q     <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
            mem_rd_en  <= 1'b0;
            wc_ovf     <= 1'b0;
            size_err   <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            mem_rd_en  <= 1'b0;
            wc_ovf     <= 1'b0;
            size_err   <= 1'b0;
            if (ld_take) begin
                addr_q <= ld_addr;
                cnt_q  <= ld_count;
                code_q <= ld_size;
                pos_q  <= '0;
            end else if (ld_bad) begin
                size_err <= 1'b1;
            end else begin
                unique case (state)
                    S_READY: if (req_live) begin
                        if (cnt_zero) wc_ovf    <= 1'b1;
                        else          mem_rd_en <= 1'b1;
                    end
                    S_FETCH: if (mem_rd_valid) begin
                        word_q     <= mem_rd_data;
                        byte_data  <= ext_byte;
                        byte_valid <= 1'b1;
                        pos_q      <= POS_W'(1);
                    end
                    S_HOLD: if (req_live) begin
                        byte_data  <= ext_byte;
                        byte_valid <= 1'b1;
                        if (last_byte) begin
                            pos_q  <= '0;
                            addr_q <= addr_q + ADDR_W'(1);
                            cnt_q  <= cnt_q - CNT_W'(1);
                        end else begin
                            pos_q <= pos_q + POS_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rdy         = (state == S_READY) || (state == S_HOLD);
    assign mem_rd_addr = addr_q;
    assign cur_addr    = addr_q;
    assign cur_count   = cnt_q;
    assign cur_pos     = pos_q;

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R4
    rd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (state == S_FETCH) && (cnt_q != '0));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wc_ovf |-> !byte_valid && !mem_rd_en && (cnt_q == '0) && (state == S_READY));

    // R7
    size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> !mem_rd_en && !byte_valid);

    // R3
    zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> ((byte_data >> cur_width) == '0));

    // R5
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_HOLD) && (state == S_READY) && !$past(ld_take)
        |-> (addr_q == $past(addr_q) + ADDR_W'(1)) && (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: tb/tb_bpu_unpacker.sv
module tb_bpu_unpacker;
    localparam int ADDR_W = 18;
    localparam int CNT_W  = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic [2:0]        ld_size = '0;
    logic [CNT_W-1:0]  ld_count = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              byte_req = 1'b0;
    logic              rdy, byte_valid, mem_rd_en, wc_ovf, size_err;
    logic [15:0]       byte_data;
    logic [ADDR_W-1:0] mem_rd_addr, cur_addr;
    logic              mem_rd_valid = 1'b0;
    logic [35:0]       mem_rd_data = '0;
    logic [CNT_W-1:0]  cur_count;
    logic [2:0]        cur_pos;

    int compared = 0;
    int mismatched = 0;
    int rd_seen = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    bpu_unpacker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_size(ld_size),
        .ld_count(ld_count), .ld_addr(ld_addr), .byte_req(byte_req),
        .rdy(rdy), .byte_valid(byte_valid), .byte_data(byte_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .wc_ovf(wc_ovf), .size_err(size_err), .cur_addr(cur_addr),
        .cur_count(cur_count), .cur_pos(cur_pos)
    );

    function automatic logic [35:0] pat(input logic [ADDR_W-1:0] a);
        return {a ^ 18'h2C5A3, ~a ^ 18'h0F1E7};
    endfunction

    function automatic int width_of(input int code);
        case (code)
            2: return 16; 3: return 12; 4: return 8; 5: return 7; 6: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] exp_byte(input logic [ADDR_W-1:0] a, input int code, input int k);
        int w;
        logic [35:0] word;
        w = width_of(code);
        word = pat(a) >> (36 - (k + 1) * w);
        return 16'(word & ((36'd1 << w) - 36'd1));
    endfunction

    // memory responder: one-cycle read latency
    always @(posedge clk) begin
        mem_rd_valid <= mem_rd_en;
        mem_rd_data  <= pat(mem_rd_addr);
    end

    // monitor: scoreboard compare and read counting
    always @(negedge clk) begin
        if (mem_rd_en) rd_seen++;
        if (byte_valid) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R3: unexpected byte act=%h exp=none", byte_data);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (byte_data !== e) begin
                    mismatched++;
                    $display("FAIL R3: byte act=%h exp=%h", byte_data, e);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input int code, input int cnt, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        load = 1'b1; ld_size = 3'(code); ld_count = CNT_W'(cnt); ld_addr = a;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic req_one(input logic [15:0] e);
        while (!rdy) @(negedge clk);
        exp_q.push_back(e);
        byte_req = 1'b1;
        @(negedge clk);
        byte_req = 1'b0;
    endtask

    task automatic run_buffer(input int code, input int cnt, input logic [ADDR_W-1:0] a, input int words);
        int bpw;
        int rd0;
        bpw = 36 / width_of(code);
        do_load(code, cnt, a);
        // R10
        check(rdy && cur_addr == a && cur_count == CNT_W'(cnt) && cur_pos == 0, "R10", longint'(cur_addr), longint'(a));
        rd0 = rd_seen;
        for (int w = 0; w < words; w++) begin
            for (int k = 0; k < bpw; k++) req_one(exp_byte(a + ADDR_W'(w), code, k));
            // R5 checked in the cycle of the last byte
            check(byte_valid && cur_addr == a + ADDR_W'(w + 1) && cur_count == CNT_W'(cnt - w - 1) && cur_pos == 0,
                  "R5", longint'(cur_addr), longint'(a + ADDR_W'(w + 1)));
        end
        // R2 R4: one read per word implies bpw bytes per word
        check(rd_seen - rd0 == words, "R4", rd_seen - rd0, words);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!finished) begin
                    mismatched++;
                    $display("FAIL watchdog: act=timeout exp=done");
                    finished = 1;
                    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                    $finish;
                end
            end
        join_none

        repeat (3) @(negedge clk);
        // R1
        check(!rdy && !byte_valid && !mem_rd_en && !wc_ovf && !size_err && cur_pos == 0, "R1", rdy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: request with rdy low does nothing
        byte_req = 1'b1;
        @(negedge clk);
        byte_req = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_seen == 0 && !rdy, "R9", rd_seen, 0);

        // R7: bad codes from idle
        for (int c = 0; c < 8; c += 7) begin
            do_load(c, 4, 18'h00100);
            check(size_err && !rdy, "R7", size_err, 1);
        end
        do_load(1, 4, 18'h00100);
        check(size_err && !rdy && rd_seen == 0, "R7", size_err, 1);

        // R2 R3 R5: every size code
        run_buffer(2, 3, 18'h00040, 2);
        run_buffer(3, 2, 18'h01234, 2);
        run_buffer(4, 2, 18'h2ABCD, 2);
        run_buffer(5, 4, 18'h00777, 3);
        run_buffer(6, 2, 18'h3FFFF, 2);   // wraps to address 0
        check(cur_addr == 18'h00001, "R5", cur_addr, 1);

        // R6: exhausted count
        run_buffer(2, 1, 18'h00500, 1);
        begin
            int rd0;
            rd0 = rd_seen;
            byte_req = 1'b1;
            @(negedge clk);
            byte_req = 1'b0;
            check(wc_ovf && !byte_valid, "R6", wc_ovf, 1);
            @(negedge clk);
            check(!wc_ovf && rd_seen == rd0 && cur_addr == 18'h00501 && cur_count == 0 && cur_pos == 0,
                  "R6", cur_addr, 18'h00501);
        end

        // R7: bad code while loaded leaves pointer intact
        do_load(4, 5, 18'h00900);
        do_load(7, 9, 18'h00AAA);
        check(size_err && rdy && cur_addr == 18'h00900 && cur_count == 5, "R7", cur_addr, 18'h00900);

        // R8: load while fetching is ignored
        req_one(exp_byte(18'h00900, 4, 0));
        load = 1'b1; ld_size = 3'd2; ld_count = 13'd1; ld_addr = 18'h00222;
        @(negedge clk);
        load = 1'b0;
        while (!byte_valid) @(negedge clk);
        check(cur_addr == 18'h00900 && cur_count == 5 && cur_pos == 1, "R8", cur_addr, 18'h00900);
        req_one(exp_byte(18'h00900, 4, 1));

        // R10: reload in mid-word discards the rest
        run_buffer(3, 1, 18'h00333, 1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule